// File: doc/BRIEF.md
# Staged power-on checkpoint sequencer

This block walks a platform through its bring-up as a chain of five checkpoints. The checkpoints, in order, are supply in window, clock lock, reset release, link-ready and fault-bit review. A checkpoint is declared good only after its status input has stayed true for a programmable run of consecutive cycles. Each checkpoint also has a timeout, and a supply or clock input that drops during the qualification run restarts that run and is counted as a re-lock event. The platform reset is released only once the supply and clock checkpoints have both been qualified.

When a checkpoint fails, a policy input picks one outcome. The sequencer can stop at once (halt), stop with the platform left in a derated start (safe), or back off and start again from the first checkpoint (retry). Retries are capped. The backoff wait doubles with each retry, and once the cap is reached the next failure halts. Every checkpoint that passes, and every failure, produces one evidence record on a valid/ready stream. The record carries a kind, a checkpoint number, a cause code and a free-running cycle stamp. If the consumer withholds ready, the record is held steady and the sequencer waits; no record is ever dropped or overwritten. The block also reports the current and previous boot cause and a cold/warm tag.

Top module: `boot_checkpoint_seq`

## Requirements
- R1: Checkpoints run in this fixed order and are numbered on cur_stage and evid_stage as 0 supply (rail_ok), 1 clock (pll_lock), 2 reset release (rail_ok and pll_lock), 3 link (link_ready) and 4 fault review.
- R2: A checkpoint passes in the cycle where its condition has been true for cfg_hold consecutive cycles, counting that cycle (0 is treated as 1). With every input already true, the stamps of two consecutive checkpoint records differ by cfg_hold+1.
- R3: rst_release is 0 from reset until the clock checkpoint passes, then 1. It returns to 0 when a retry is taken or the block halts, and it is left unchanged on a safe route.
- R4: A checkpoint that has not passed within cfg_timeout cycles fails with cause code number+1. If the pass and the expiry fall in the same cycle, the pass wins.
- R5: At checkpoint 4, any bit set in fault_bits & cfg_crit_mask fails the checkpoint at once with cause 6. Fault bits outside the mask have no effect.
- R6: cfg_route selects 0 halt, 1 safe or 2 retry (3 behaves as halt). The route output reads 0 while running or done, 1 halt, 2 safe and 3 while backing off. Each failure yields exactly one record, of kind 1 halt, 2 safe or 3 retry.
- R7: A retry is taken only while retry_cnt < cfg_retry_max. Each retry raises retry_cnt by one and emits a kind-3 record carrying the failing checkpoint and its cause. Once the cap is reached, a failure under the retry policy halts.
- R8: After the n-th retry (n counting from 0), the sequencer waits cfg_backoff_base << n cycles beyond its fixed overhead, then restarts at checkpoint 0 with route back at 0.
- R9: If a condition drops while its qualification run is non-zero, the run restarts from zero and relock_cnt (saturating) increments.
- R10: Evidence uses valid/ready. A record is transferred on a cycle where both are high, and its fields stay stable while valid is high and ready is low. The sequencer does not advance until the transfer. A checkpoint pass is recorded as kind 0 with cause 0. Stamps strictly increase.
- R11: lkg_stage holds the number of the last checkpoint passed. It reads 7 after reset and after each retry.
- R12: At start, cause_cur loads boot_cause_i and warm_tag loads boot_warm_i, while cause_prev reads 0. On each retry, cause_prev takes cause_cur, cause_cur becomes 8 + the failure cause, and warm_tag is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_cause_i | input | 4 | Boot cause presented at start |
| boot_warm_i | input | 1 | 1 when the start is a warm restart |
| cfg_hold | input | HOLD_W | Qualification run length in cycles |
| cfg_timeout | input | TMO_W | Per-checkpoint timeout in cycles |
| cfg_route | input | 2 | Failure policy: 0 halt, 1 safe, 2 retry |
| cfg_retry_max | input | RETRY_W | Retry cap |
| cfg_backoff_base | input | BACKOFF_W | First backoff wait |
| cfg_crit_mask | input | FAULT_W | Fault bits treated as critical |
| rail_ok | input | 1 | Supply-in-window status |
| pll_lock | input | 1 | Clock lock status |
| link_ready | input | 1 | Link-ready status |
| fault_bits | input | FAULT_W | Latched fault bits |
| rst_release | output | 1 | Platform reset release |
| cur_stage | output | 3 | Checkpoint being qualified |
| lkg_stage | output | 3 | Last checkpoint passed, 7 if none |
| route | output | 2 | 0 none, 1 halt, 2 safe, 3 retry/backoff |
| boot_done | output | 1 | All checkpoints passed |
| retry_cnt | output | RETRY_W | Retries taken |
| relock_cnt | output | CNT_W | Condition drops during qualification |
| cause_cur | output | 4 | Current boot cause |
| cause_prev | output | 4 | Previous boot cause |
| warm_tag | output | 1 | Warm-boot tag |
| evid_valid | output | 1 | Evidence record valid |
| evid_ready | input | 1 | Evidence consumer ready |
| evid_kind | output | 2 | 0 pass, 1 halt, 2 safe, 3 retry |
| evid_stage | output | 3 | Checkpoint number of the record |
| evid_cause | output | 4 | Cause code of the record |
| evid_stamp | output | STAMP_W | Cycle stamp at detection |

## Verification
Two events can land in the same cycle: the last cycle of a qualification run and the expiry of the checkpoint timeout. The bench provokes this by making cfg_hold equal to cfg_timeout with the condition true from entry, and it expects a pass. It then raises cfg_hold by one, which must produce a timeout failure on checkpoint 0 with cause 1. A second collision occurs at checkpoint 4, where a critical fault and a qualifying run could coincide. The bench judges it by the record's kind, checkpoint number and cause, and by the final route.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;
  localparam logic [2:0] STG_RAIL = 3'd0;
  localparam logic [2:0] STG_CLK  = 3'd1;
  localparam logic [2:0] STG_RREL = 3'd2;
  localparam logic [2:0] STG_LINK = 3'd3;
  localparam logic [2:0] STG_FLT  = 3'd4;
  localparam logic [2:0] STG_NONE = 3'd7;

  localparam logic [1:0] POL_HALT  = 2'd0;
  localparam logic [1:0] POL_SAFE  = 2'd1;
  localparam logic [1:0] POL_RETRY = 2'd2;

  localparam logic [1:0] RT_NONE  = 2'd0;
  localparam logic [1:0] RT_HALT  = 2'd1;
  localparam logic [1:0] RT_SAFE  = 2'd2;
  localparam logic [1:0] RT_RETRY = 2'd3;

  localparam logic [3:0] CAUSE_CRIT = 4'd6;

  typedef enum logic [1:0] {K_PASS = 2'd0, K_HALT = 2'd1, K_SAFE = 2'd2, K_RETRY = 2'd3} kind_e;
  typedef enum logic [2:0] {S_INIT, S_RUN, S_EMIT, S_BACKOFF, S_DONE, S_STOP} fsm_e;
  typedef enum logic [1:0] {A_NEXT, A_DONE, A_BACKOFF, A_STOP} act_e;
endpackage

// File: rtl/bootseq_qualifier.sv
module bootseq_qualifier #(
  parameter int HOLD_W = 16,
  parameter int TMO_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cond,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic [TMO_W-1:0]  cfg_timeout,
  output logic              pass,
  output logic              expire,
  output logic [CNT_W-1:0]  relock_cnt
);
  logic [HOLD_W-1:0] hold_cnt;
  logic [HOLD_W-1:0] hold_goal;
  logic [TMO_W-1:0]  tmo_cnt;

  assign hold_goal = (cfg_hold == '0) ? '0 : cfg_hold - HOLD_W'(1);
  assign pass      = active && cond && (hold_cnt >= hold_goal);
  assign expire    = active && (({1'b0, tmo_cnt} + (TMO_W+1)'(1)) >= {1'b0, cfg_timeout});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt   <= '0;
      tmo_cnt    <= '0;
      relock_cnt <= '0;
    end else begin
      if (!active) begin
        hold_cnt <= '0;
        tmo_cnt  <= '0;
      end else begin
        if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + TMO_W'(1);
        if (cond) begin
          if (hold_cnt != '1) hold_cnt <= hold_cnt + HOLD_W'(1);
        end else begin
          hold_cnt <= '0;
        end
      end
      if (active && !cond && (hold_cnt != '0) && (relock_cnt != '1))
        relock_cnt <= relock_cnt + CNT_W'(1);
    end
  end

  // R9
  glitch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cond && (hold_cnt != '0) && (relock_cnt != '1))
      |=> (relock_cnt == $past(relock_cnt) + CNT_W'(1)) && (hold_cnt == '0));
endmodule

// File: rtl/bootseq_backoff.sv
module bootseq_backoff #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (en && cnt != '0) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/bootseq_evidence.sv
module bootseq_evidence #(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         in_kind,
  input  logic [2:0]         in_stage,
  input  logic [3:0]         in_cause,
  input  logic [STAMP_W-1:0] in_stamp,
  output logic               valid,
  input  logic               ready,
  output logic [1:0]         kind,
  output logic [2:0]         stage,
  output logic [3:0]         cause,
  output logic [STAMP_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      kind  <= '0;
      stage <= '0;
      cause <= '0;
      stamp <= '0;
    end else if (load) begin
      valid <= 1'b1;
      kind  <= in_kind;
      stage <= in_stage;
      cause <= in_cause;
      stamp <= in_stamp;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R10
  evid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(kind) && $stable(stage) && $stable(cause) && $stable(stamp)));
endmodule

// File: rtl/boot_checkpoint_seq.sv
module boot_checkpoint_seq
  import bootseq_pkg::*;
#(
  parameter int HOLD_W    = 16,
  parameter int TMO_W     = 16,
  parameter int RETRY_W   = 3,
  parameter int BACKOFF_W = 16,
  parameter int FAULT_W   = 8,
  parameter int CNT_W     = 8,
  parameter int STAMP_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           boot_cause_i,
  input  logic                 boot_warm_i,
  input  logic [HOLD_W-1:0]    cfg_hold,
  input  logic [TMO_W-1:0]     cfg_timeout,
  input  logic [1:0]           cfg_route,
  input  logic [RETRY_W-1:0]   cfg_retry_max,
  input  logic [BACKOFF_W-1:0] cfg_backoff_base,
  input  logic [FAULT_W-1:0]   cfg_crit_mask,
  input  logic                 rail_ok,
  input  logic                 pll_lock,
  input  logic                 link_ready,
  input  logic [FAULT_W-1:0]   fault_bits,
  output logic                 rst_release,
  output logic [2:0]           cur_stage,
  output logic [2:0]           lkg_stage,
  output logic [1:0]           route,
  output logic                 boot_done,
  output logic [RETRY_W-1:0]   retry_cnt,
  output logic [CNT_W-1:0]     relock_cnt,
  output logic [3:0]           cause_cur,
  output logic [3:0]           cause_prev,
  output logic                 warm_tag,
  output logic                 evid_valid,
  input  logic                 evid_ready,
  output logic [1:0]           evid_kind,
  output logic [2:0]           evid_stage,
  output logic [3:0]           evid_cause,
  output logic [STAMP_W-1:0]   evid_stamp
);
  localparam int BO_W = BACKOFF_W + (1 << RETRY_W);

  fsm_e               state_q;
  act_e               act_q;
  logic [2:0]         stage_q, lkg_q;
  logic [1:0]         route_q;
  logic [RETRY_W-1:0] retry_q;
  logic [3:0]         ccur_q, cprev_q;
  logic               warm_q, rel_q;
  logic [STAMP_W-1:0] stamp_q;

  logic       run, cond, crit_any, crit_fail, ok_now, fail_now, can_retry;
  logic       q_pass, q_expire, bo_zero, evid_hs;
  logic [3:0] fail_cause;
  kind_e      fail_kind;
  logic [BO_W-1:0] bo_delay;

  assign crit_any = |(fault_bits & cfg_crit_mask);
  assign run      = (state_q == S_RUN);

  always_comb begin
    case (stage_q)
      STG_RAIL: cond = rail_ok;
      STG_CLK:  cond = pll_lock;
      STG_RREL: cond = rail_ok && pll_lock;
      STG_LINK: cond = link_ready;
      STG_FLT:  cond = !crit_any;
      default:  cond = 1'b0;
    endcase
  end

  bootseq_qualifier #(.HOLD_W(HOLD_W), .TMO_W(TMO_W), .CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .active(run), .cond(cond),
    .cfg_hold(cfg_hold), .cfg_timeout(cfg_timeout),
    .pass(q_pass), .expire(q_expire), .relock_cnt(relock_cnt)
  );

  always_comb begin
    crit_fail  = run && (stage_q == STG_FLT) && crit_any;
    ok_now     = run && !crit_fail && q_pass;
    fail_now   = crit_fail || (run && !q_pass && q_expire);
    fail_cause = crit_fail ? CAUSE_CRIT : {1'b0, stage_q + 3'd1};
    can_retry  = (cfg_route == POL_RETRY) && (retry_q < cfg_retry_max);
    if (can_retry)                  fail_kind = K_RETRY;
    else if (cfg_route == POL_SAFE) fail_kind = K_SAFE;
    else                            fail_kind = K_HALT;
  end

  assign bo_delay = BO_W'(cfg_backoff_base) << retry_q;

  bootseq_backoff #(.W(BO_W)) u_backoff (
    .clk(clk), .rst_n(rst_n),
    .load(fail_now && (fail_kind == K_RETRY)), .load_val(bo_delay),
    .en(state_q == S_BACKOFF), .zero(bo_zero)
  );

  bootseq_evidence #(.STAMP_W(STAMP_W)) u_evid (
    .clk(clk), .rst_n(rst_n),
    .load(ok_now || fail_now),
    .in_kind(ok_now ? K_PASS : fail_kind),
    .in_stage(stage_q),
    .in_cause(ok_now ? 4'd0 : fail_cause),
    .in_stamp(stamp_q),
    .valid(evid_valid), .ready(evid_ready),
    .kind(evid_kind), .stage(evid_stage), .cause(evid_cause), .stamp(evid_stamp)
  );

  assign evid_hs = evid_valid && evid_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_INIT;
      act_q   <= A_NEXT;
      stage_q <= STG_RAIL;
      lkg_q   <= STG_NONE;
      route_q <= RT_NONE;
      retry_q <= '0;
      ccur_q  <= '0;
      cprev_q <= '0;
      warm_q  <= 1'b0;
      rel_q   <= 1'b0;
      stamp_q <= '0;
    end else begin
      stamp_q <= stamp_q + STAMP_W'(1);
      case (state_q)
        S_INIT: begin
          ccur_q  <= boot_cause_i;
          cprev_q <= 4'd0;
          warm_q  <= boot_warm_i;
          stage_q <= STG_RAIL;
          state_q <= S_RUN;
        end
        S_RUN: begin
          if (ok_now) begin
            lkg_q   <= stage_q;
            if (stage_q == STG_CLK) rel_q <= 1'b1;
            act_q   <= (stage_q == STG_FLT) ? A_DONE : A_NEXT;
            state_q <= S_EMIT;
          end else if (fail_now) begin
            state_q <= S_EMIT;
            case (fail_kind)
              K_RETRY: begin
                retry_q <= retry_q + RETRY_W'(1);
                cprev_q <= ccur_q;
                ccur_q  <= {1'b1, fail_cause[2:0]};
                warm_q  <= 1'b1;
                lkg_q   <= STG_NONE;
                rel_q   <= 1'b0;
                route_q <= RT_RETRY;
                act_q   <= A_BACKOFF;
              end
              K_SAFE: begin
                route_q <= RT_SAFE;
                act_q   <= A_STOP;
              end
              default: begin
                route_q <= RT_HALT;
                rel_q   <= 1'b0;
                act_q   <= A_STOP;
              end
            endcase
          end
        end
        S_EMIT: begin
          if (evid_hs) begin
            case (act_q)
              A_NEXT: begin
                stage_q <= stage_q + 3'd1;
                state_q <= S_RUN;
              end
              A_DONE:    state_q <= S_DONE;
              A_BACKOFF: state_q <= S_BACKOFF;
              default:   state_q <= S_STOP;
            endcase
          end
        end
        S_BACKOFF: begin
          if (bo_zero) begin
            stage_q <= STG_RAIL;
            route_q <= RT_NONE;
            state_q <= S_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign rst_release = rel_q;
  assign cur_stage   = stage_q;
  assign lkg_stage   = lkg_q;
  assign route       = route_q;
  assign boot_done   = (state_q == S_DONE);
  assign retry_cnt   = retry_q;
  assign cause_cur   = ccur_q;
  assign cause_prev  = cprev_q;
  assign warm_tag    = warm_q;

  // R3
  rel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release |-> ((lkg_stage != STG_NONE) && (lkg_stage >= STG_CLK)));

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(route == RT_RETRY) |-> (retry_cnt <= cfg_retry_max) && (retry_cnt != '0));

  // R6
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (route == RT_NONE));
endmodule

// File: tb/boot_checkpoint_seq_bench.sv
`timescale 1ns/1ps
module boot_checkpoint_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] boot_cause_i = '0;
  logic boot_warm_i = 1'b0;
  logic [15:0] cfg_hold = 16'd4, cfg_timeout = 16'd50, cfg_backoff_base = 16'd8;
  logic [1:0] cfg_route = 2'd0;
  logic [2:0] cfg_retry_max = 3'd2;
  logic [7:0] cfg_crit_mask = 8'h0F, fault_bits = 8'h00;
  logic rail_ok = 1'b1, pll_lock = 1'b1, link_ready = 1'b1, evid_ready = 1'b1;
  logic rst_release, boot_done, warm_tag, evid_valid;
  logic [2:0] cur_stage, lkg_stage, retry_cnt, evid_stage;
  logic [1:0] route, evid_kind;
  logic [7:0] relock_cnt;
  logic [3:0] cause_cur, cause_prev, evid_cause;
  logic [31:0] evid_stamp;

  int nvec = 0, nerr = 0, nrec = 0;
  logic [1:0] rk [0:15];
  logic [2:0] rs [0:15];
  logic [3:0] rc [0:15];
  logic [31:0] rt [0:15];

  always #2.5 clk = ~clk;

  boot_checkpoint_seq u_boot_checkpoint_seq (
    .clk(clk), .rst_n(rst_n), .boot_cause_i(boot_cause_i), .boot_warm_i(boot_warm_i),
    .cfg_hold(cfg_hold), .cfg_timeout(cfg_timeout), .cfg_route(cfg_route),
    .cfg_retry_max(cfg_retry_max), .cfg_backoff_base(cfg_backoff_base),
    .cfg_crit_mask(cfg_crit_mask), .rail_ok(rail_ok), .pll_lock(pll_lock),
    .link_ready(link_ready), .fault_bits(fault_bits), .rst_release(rst_release),
    .cur_stage(cur_stage), .lkg_stage(lkg_stage), .route(route), .boot_done(boot_done),
    .retry_cnt(retry_cnt), .relock_cnt(relock_cnt), .cause_cur(cause_cur),
    .cause_prev(cause_prev), .warm_tag(warm_tag), .evid_valid(evid_valid),
    .evid_ready(evid_ready), .evid_kind(evid_kind), .evid_stage(evid_stage),
    .evid_cause(evid_cause), .evid_stamp(evid_stamp)
  );

  always @(negedge clk) begin
    if (!rst_n) nrec = 0;
    else if (evid_valid && evid_ready && nrec < 16) begin
      rk[nrec] = evid_kind; rs[nrec] = evid_stage; rc[nrec] = evid_cause; rt[nrec] = evid_stamp;
      nrec = nrec + 1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_reset();
    @(negedge clk);
    rst_n = 1'b0;
    boot_cause_i = 4'd0; boot_warm_i = 1'b0;
    cfg_hold = 16'd4; cfg_timeout = 16'd50; cfg_route = 2'd0; cfg_retry_max = 3'd2;
    cfg_backoff_base = 16'd8; cfg_crit_mask = 8'h0F; fault_bits = 8'h00;
    rail_ok = 1'b1; pll_lock = 1'b1; link_ready = 1'b1; evid_ready = 1'b1;
  endtask

  task automatic release_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(boot_done || route == 2'd1 || route == 2'd2) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    begin_reset();
    repeat (2) @(negedge clk);
    chk("R3", "rst_release in reset", rst_release, 0);
    chk("R11", "lkg in reset", lkg_stage, 7);
    chk("R6", "route in reset", route, 0);
    chk("R10", "evid_valid in reset", evid_valid, 0);
    chk("R1", "cur_stage in reset", cur_stage, 0);
    release_reset();
  endtask

  task automatic t_clean();
    begin_reset();
    boot_cause_i = 4'd3; cfg_hold = 16'd6;
    release_reset();
    wait_end();
    chk("R1", "record count", nrec, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R1", "record stage", rs[i], i);
      chk("R10", "record kind", rk[i], 0);
    end
    for (int i = 1; i < 5; i++) chk("R2", "stamp spacing", rt[i] - rt[i-1], 7);
    chk("R1", "boot_done", boot_done, 1);
    chk("R11", "lkg after boot", lkg_stage, 4);
    chk("R3", "rst_release after boot", rst_release, 1);
    chk("R12", "cause_cur", cause_cur, 3);
    chk("R12", "cause_prev", cause_prev, 0);
    chk("R12", "warm_tag", warm_tag, 0);
  endtask

  task automatic t_gate();
    begin_reset();
    pll_lock = 1'b0; cfg_timeout = 16'd1000;
    release_reset();
    repeat (40) @(negedge clk);
    chk("R3", "stage waiting on clock", cur_stage, 1);
    chk("R3", "reset held before clock", rst_release, 0);
    chk("R11", "lkg after supply", lkg_stage, 0);
    pll_lock = 1'b1;
    wait_end();
    chk("R3", "reset released", rst_release, 1);
    chk("R3", "boot completes", boot_done, 1);
  endtask

  task automatic t_glitch();
    begin_reset();
    rail_ok = 1'b0; cfg_hold = 16'd20; cfg_timeout = 16'd1000;
    release_reset();
    repeat (5) @(negedge clk); rail_ok = 1'b1;
    repeat (3) @(negedge clk); rail_ok = 1'b0;
    repeat (2) @(negedge clk); rail_ok = 1'b1;
    repeat (5) @(negedge clk); rail_ok = 1'b0;
    repeat (2) @(negedge clk); rail_ok = 1'b1;
    wait_end();
    chk("R9", "relock count", relock_cnt, 2);
    chk("R9", "boot after glitches", boot_done, 1);
  endtask

  task automatic t_boundary();
    begin_reset();
    cfg_hold = 16'd6; cfg_timeout = 16'd6;
    release_reset();
    wait_end();
    chk("R4", "hold equals timeout passes", boot_done, 1);
    begin_reset();
    cfg_hold = 16'd7; cfg_timeout = 16'd6;
    release_reset();
    wait_end();
    chk("R4", "record count", nrec, 1);
    chk("R4", "fail kind", rk[0], 1);
    chk("R4", "fail stage", rs[0], 0);
    chk("R4", "fail cause", rc[0], 1);
    chk("R6", "route halt", route, 1);
    chk("R11", "lkg none", lkg_stage, 7);
    chk("R3", "reset held after halt", rst_release, 0);
  endtask

  task automatic t_fault();
    begin_reset();
    cfg_route = 2'd1; fault_bits = 8'h30;
    release_reset();
    wait_end();
    chk("R5", "masked-off bits ignored", boot_done, 1);
    chk("R5", "records with masked bits", nrec, 5);
    begin_reset();
    cfg_route = 2'd1; fault_bits = 8'h04;
    release_reset();
    wait_end();
    chk("R5", "record count", nrec, 5);
    chk("R6", "safe kind", rk[4], 2);
    chk("R5", "fault stage", rs[4], 4);
    chk("R5", "critical cause", rc[4], 6);
    chk("R6", "route safe", route, 2);
    chk("R11", "lkg at link", lkg_stage, 3);
    chk("R3", "safe keeps reset", rst_release, 1);
  endtask

  task automatic t_retry();
    begin_reset();
    cfg_route = 2'd2; cfg_retry_max = 3'd2; cfg_backoff_base = 16'd8;
    cfg_timeout = 16'd20; pll_lock = 1'b0; boot_cause_i = 4'd5;
    release_reset();
    wait_end();
    chk("R7", "record count", nrec, 6);
    chk("R7", "first retry kind", rk[1], 3);
    chk("R7", "retry stage", rs[1], 1);
    chk("R7", "retry cause", rc[1], 2);
    chk("R7", "second retry kind", rk[3], 3);
    chk("R8", "restart at stage 0", rs[2], 0);
    chk("R7", "final halt kind", rk[5], 1);
    chk("R7", "retry count", retry_cnt, 2);
    chk("R7", "route halt after cap", route, 1);
    chk("R8", "backoff doubling", (rt[4] - rt[3]) - (rt[2] - rt[1]), 8);
    chk("R12", "cause_cur after retry", cause_cur, 10);
    chk("R12", "cause_prev after retry", cause_prev, 10);
    chk("R12", "warm tag after retry", warm_tag, 1);
  endtask

  task automatic t_stall();
    int n = 0;
    begin_reset();
    evid_ready = 1'b0;
    release_reset();
    while (!evid_valid && n < 200) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    chk("R10", "stalled stage", cur_stage, 0);
    chk("R10", "valid held", evid_valid, 1);
    chk("R10", "held kind", evid_kind, 0);
    chk("R10", "no transfer", nrec, 0);
    evid_ready = 1'b1;
    wait_end();
    chk("R10", "records after stall", nrec, 5);
    chk("R10", "boot after stall", boot_done, 1);
  endtask

  initial begin
    t_reset_state();
    t_clean();
    t_gate();
    t_glitch();
    t_boundary();
    t_fault();
    t_retry();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule